// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits behind a memory-mapped read window and turns each bus read into a complete serial flash read sequence. A bus read pulls chip select low. The block then shifts out a read opcode, the address and any dummy bytes on one data line. After that it collects a data word from the flash, either on one line or on four lines, and hands the word back to the bus with a one-cycle completion pulse.

A 32-bit setup word sets the shape of the sequence: the opcode, how many address bytes are sent, how many dummy bytes are sent, and whether the data phase uses one line or four. A separate mode bit selects between two modes. In memory-mapped mode, bus reads are translated. In register-driven mode, bus reads are refused with an error response and no serial activity occurs. Both are written through a small register write port. The serial clock runs at half the system clock, idles low, and samples on its rising edge.

Top module: `sfr_xlate`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `rd_ready` is 1, `rd_done` is 0 and the mode bit is clear. The setup word resets to opcode 0x03, address field 2, no dummy bytes and single-line data.
- R2: A write with `reg_sel`=0 loads the setup word. A write with `reg_sel`=1 loads the mode bit from `reg_wdata[0]`, where 1 means memory-mapped mode.
- R3: A read accepted while the mode bit is clear gives `rd_done` and `rd_err` both at 1 in the very next cycle, with `rd_data` 0. `cs_n` never falls for it.
- R4: The opcode from setup bits 7:0 goes out first, MSB first, on `io_out[0]` with `io_oe`=0001. `sclk` has a period of two clock cycles, is high for one cycle, and data changes only while it is low.
- R5: Setup bits 9:8 hold a value n, and n+1 address bytes follow the opcode. They are sent MSB first and taken from `rd_addr`, zero-extended to 32 bits.
- R6: Setup bits 11:10 hold a count of dummy bytes, from 0 to 3. Each dummy byte is eight `sclk` periods with `io_out[0]` low.
- R7: When setup bits 13:12 equal 3, each data byte takes two `sclk` periods on `io_in[3:0]`, high nibble first. Any other value gives single-line data on `io_in[1]`, MSB first. `io_oe` is 0 during data.
- R8: The first data byte received lands in `rd_data[31:24]`. `rd_done` is a one-cycle pulse with `cs_n` high, and it arrives 2*(command bits + data units) + 1 cycles after the cycle in which the read was accepted.
- R9: `rd_ready` is low while chip select is active. A `rd_valid` raised in that time is ignored and starts no further sequence.
- R10: Setup bits 23:16 (write opcode) and 29:24 (dummy bit count) are stored, but they change neither the serial sequence nor the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects setup word, 1 selects mode bit |
| reg_wdata | input | 32 | Register write data |
| rd_valid | input | 1 | Bus read request |
| rd_addr | input | ADDR_W | Bus read byte address |
| rd_ready | output | 1 | Read request can be accepted |
| rd_done | output | 1 | Read complete, one-cycle pulse |
| rd_err | output | 1 | Read refused (register-driven mode) |
| rd_data | output | DATA_W | Read data word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Serial data output enables |
| io_in | input | 4 | Serial data in |

## Verification
Some properties are checked on every cycle. Chip select and the serial clock stay quiet while idle. The serial clock is high for one cycle at a time and never runs with chip select high. Only line 0 is ever driven. A refused read answers one cycle later with chip select high, and the completion pulse lasts one cycle. Other behaviour can only be shown by the bench's flash model, which decodes the serial stream as it arrives. That covers the opcode, the address width and value, the dummy bits, the nibble and bit order of the data and the exact completion latency. It also covers the fact that the write opcode fields and the reads raised while busy have no effect.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_RESP
    } seq_state_e;

    // Field positions follow the setup word layout used by software.
    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [5:0] dmy_bits;
        logic [7:0] wr_op;
        logic [1:0] rsv_lo;
        logic [1:0] rtype;
        logic [1:0] dmy_fld;
        logic [1:0] addr_fld;
        logic [7:0] rd_op;
    } setup_t;

    typedef struct packed {
        setup_t setup;
        logic   mm;
    } cfg_state_t;

    localparam setup_t SETUP_RST = '{rsv_hi: 2'd0, dmy_bits: 6'd0, wr_op: 8'h00,
                                     rsv_lo: 2'd0, rtype: 2'd0, dmy_fld: 2'd0,
                                     addr_fld: 2'd2, rd_op: 8'h03};

    localparam logic [1:0] RTYPE_QUAD = 2'd3;

endpackage

// File: rtl/sfr_cfg_regs.sv
module sfr_cfg_regs
    import sfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output setup_t      setup,
    output logic        mm_on
);

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            if (reg_sel) begin
                cfg_d.mm = reg_wdata[0];
            end else begin
                cfg_d.setup        = setup_t'(reg_wdata);
                cfg_d.setup.rsv_hi = 2'd0;
                cfg_d.setup.rsv_lo = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{setup: SETUP_RST, mm: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign setup = cfg_q.setup;
    assign mm_on = cfg_q.mm;

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  setup_t            setup,
    input  logic              mm_on,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_done,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    localparam int FULL_A = 32;
    localparam int TX_W   = 8 + FULL_A + 24;
    localparam int CNT_W  = $clog2(TX_W + 1);
    localparam int NIB_N  = DATA_W / 4;

    typedef struct packed {
        seq_state_e         st;
        logic               sclk;
        logic               quad;
        logic               err;
        logic [TX_W-1:0]    tx;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  rx;
    } seq_t;

    seq_t s_d, s_q;

    logic [2:0]        nab;
    logic [FULL_A-1:0] addr_full;
    logic [FULL_A-1:0] addr_al;
    logic [5:0]        shamt;
    logic [CNT_W-1:0]  cmd_bits;

    logic unused_fields;
    assign unused_fields = ^{setup.wr_op, setup.dmy_bits, setup.rsv_hi, setup.rsv_lo};

    always_comb begin
        nab       = {1'b0, setup.addr_fld} + 3'd1;
        addr_full = FULL_A'(rd_addr);
        shamt     = {(3'd4 - nab), 3'b000};
        addr_al   = addr_full << shamt;
        cmd_bits  = CNT_W'(8) + CNT_W'({nab, 3'b000}) + CNT_W'({setup.dmy_fld, 3'b000});
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (rd_valid) begin
                    if (!mm_on) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_RESP;
                    end else begin
                        s_d.err  = 1'b0;
                        s_d.quad = (setup.rtype == RTYPE_QUAD);
                        s_d.tx   = {setup.rd_op, addr_al, 24'h0};
                        s_d.cnt  = cmd_bits;
                        s_d.rx   = '0;
                        s_d.st   = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (!s_q.sclk) begin
                    s_d.sclk = 1'b1;
                end else begin
                    s_d.sclk = 1'b0;
                    s_d.tx   = s_q.tx << 1;
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d.st  = ST_DATA;
                        s_d.cnt = s_q.quad ? CNT_W'(NIB_N) : CNT_W'(DATA_W);
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (!s_q.sclk) begin
                    s_d.sclk = 1'b1;
                    s_d.rx   = s_q.quad ? {s_q.rx[DATA_W-5:0], io_in}
                                        : {s_q.rx[DATA_W-2:0], io_in[1]};
                end else begin
                    s_d.sclk = 1'b0;
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d.st = ST_RESP;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_RESP: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, sclk: 1'b0, quad: 1'b0, err: 1'b0,
                     tx: '0, cnt: '0, rx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ready = (s_q.st == ST_IDLE);
    assign rd_done  = (s_q.st == ST_RESP);
    assign rd_err   = rd_done && s_q.err;
    assign rd_data  = (rd_done && !s_q.err) ? s_q.rx : '0;
    assign sclk     = s_q.sclk;
    assign cs_n     = !((s_q.st == ST_CMD) || (s_q.st == ST_DATA));
    assign io_out   = {3'b000, (s_q.st == ST_CMD) && s_q.tx[TX_W-1]};
    assign io_oe    = {3'b000, (s_q.st == ST_CMD)};

endmodule

// File: rtl/sfr_xlate.sv
module sfr_xlate
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_done,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    setup_t setup;
    logic   mm_on;

    sfr_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .setup     (setup),
        .mm_on     (mm_on)
    );

    sfr_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .setup    (setup),
        .mm_on    (mm_on),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .rd_ready (rd_ready),
        .rd_done  (rd_done),
        .rd_err   (rd_err),
        .rd_data  (rd_data),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .io_in    (io_in)
    );

endmodule

// File: rtl/sfr_xlate_chk.sv
module sfr_xlate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       rd_done,
    input logic       rd_err,
    input logic       sclk,
    input logic       cs_n,
    input logic [3:0] io_oe,
    input logic       mm_on
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (cs_n && !sclk));

    assert_refuse_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !mm_on) |=> (rd_done && rd_err && cs_n));

    assert_sclk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_sclk_high_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    assert_oe_line0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'b0000) |-> (!cs_n && io_oe == 4'b0001));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    assert_done_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> cs_n);

    assert_err_implies_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_done);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !rd_ready);

endmodule

bind sfr_xlate sfr_xlate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_done  (rd_done),
    .rd_err   (rd_err),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .io_oe    (io_oe),
    .mm_on    (mm_on)
);

// File: tb/sim_sfr_xlate.sv
`timescale 1ns/1ps
module sim_sfr_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_ready, rd_done, rd_err, sclk, cs_n;
    logic [31:0] rd_data;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench-side copy of the configuration it programmed
    logic [7:0] b_op = 8'h03;
    int b_nab = 3;
    int b_ndm = 0;
    bit b_quad = 1'b0;

    // flash model state
    int          fm_total = 0;
    int          fm_falls = 0;
    logic [63:0] fm_cmd = '0;

    always #2.5 clk = ~clk;

    sfr_xlate u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_done(rd_done), .rd_err(rd_err),
        .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    function automatic int cmd_bits();
        return 8 + 8 * b_nab + 8 * b_ndm;
    endfunction

    function automatic logic [31:0] amask(int nab);
        return (nab >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nab)) - 32'h1);
    endfunction

    function automatic logic [7:0] fbyte(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ {a[3:0], a[23:20]} ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] a);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) w = {w[23:0], fbyte(a + 32'(k))};
        return w;
    endfunction

    function automatic logic [31:0] fm_addr();
        logic [63:0] t = fm_cmd >> (8 * b_ndm);
        return t[31:0] & amask(b_nab);
    endfunction

    function automatic logic [31:0] mk_setup(logic [7:0] op, logic [1:0] af,
            logic [1:0] df, logic [1:0] rt, logic [7:0] wop, logic [5:0] db);
        return {2'b00, db, wop, 2'b00, rt, df, af, op};
    endfunction

    // flash model: command capture on rising sclk, counting from chip select fall
    always @(negedge cs_n or posedge sclk) begin
        if (!sclk) begin
            fm_total = 0;
            fm_cmd   = '0;
            fm_falls = fm_falls + 1;
        end else if (!cs_n) begin
            fm_total = fm_total + 1;
            if (fm_total <= cmd_bits()) fm_cmd = {fm_cmd[62:0], io_out[0]};
        end
    end

    // flash model: data launch on falling sclk
    always @(negedge sclk) begin
        if (!cs_n && fm_total >= cmd_bits()) begin
            int u;
            logic [7:0] by;
            u = fm_total - cmd_bits();
            if (b_quad) begin
                by = fbyte(fm_addr() + 32'(u / 2));
                io_in <= (u % 2 == 0) ? by[7:4] : by[3:0];
            end else begin
                by = fbyte(fm_addr() + 32'(u / 8));
                io_in <= {2'b00, by[7 - (u % 8)], 1'b0};
            end
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(bit sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_cfg(logic [7:0] op, logic [1:0] af, logic [1:0] df,
                           logic [1:0] rt, logic [7:0] wop, logic [5:0] db);
        wr_reg(1'b0, mk_setup(op, af, df, rt, wop, db));
        b_op = op; b_nab = int'(af) + 1; b_ndm = int'(df); b_quad = (rt == 2'd3);
    endtask

    task automatic do_read(logic [23:0] a, bit expect_err, bit poke);
        int lat, falls0, exp_lat;
        logic [31:0] ea, got;
        logic [63:0] t;
        bit er;
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        falls0 = fm_falls;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        lat = 1;
        while (!rd_done && lat < 2000) begin
            if (poke && lat == 5) begin rd_valid = 1'b1; rd_addr = ~a; end
            else rd_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd_valid = 1'b0;
        got = rd_data; er = rd_err;
        if (expect_err) begin
            check(er == 1'b1, "R3 err flag", 64'(er), 64'd1);
            check(lat == 1, "R3 err latency", 64'(lat), 64'd1);
            check(got == 32'h0, "R3 err data", 64'(got), 64'd0);
            check(fm_falls == falls0, "R3 no chip select", 64'(fm_falls), 64'(falls0));
        end else begin
            ea = 32'(a) & amask(b_nab);
            exp_lat = 1 + 2 * cmd_bits() + 2 * (b_quad ? 8 : 32);
            t = fm_cmd >> (8 * (b_nab + b_ndm));
            check(er == 1'b0, "R8 no err", 64'(er), 64'd0);
            check(t[7:0] == b_op, "R4 opcode", 64'(t[7:0]), 64'(b_op));
            check(fm_addr() == ea, "R5 address", 64'(fm_addr()), 64'(ea));
            check((fm_cmd & 64'(amask(b_ndm))) == 64'h0, "R6 dummy low",
                  fm_cmd & 64'(amask(b_ndm)), 64'h0);
            check(fm_total == cmd_bits() + (b_quad ? 8 : 32), "R6 R7 R10 sclk count",
                  64'(fm_total), 64'(cmd_bits() + (b_quad ? 8 : 32)));
            check(got == exp_word(ea), "R7 R8 data", 64'(got), 64'(exp_word(ea)));
            check(lat == exp_lat, "R8 latency", 64'(lat), 64'(exp_lat));
        end
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(cs_n == 1'b1 && !rd_done, "R9 stray request ignored",
                      64'({cs_n, rd_done}), 64'b10);
            end
            check(fm_falls == falls0 + 1, "R9 one sequence", 64'(fm_falls), 64'(falls0 + 1));
        end
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && rd_ready == 1'b1 && rd_done == 1'b0,
              "R1 reset outputs", 64'({cs_n, sclk, rd_ready, rd_done}), 64'b1010);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && rd_ready == 1'b1, "R1 after release",
              64'({cs_n, rd_ready}), 64'b11);

        // R1 mode bit clear after reset -> refused
        do_read(24'h001234, 1'b1, 1'b0);
        // R2 mode switch on; R1 reset setup is a plain 3-byte read
        wr_reg(1'b1, 32'h1);
        do_read(24'h012345, 1'b0, 1'b0);
        do_read(24'h000000, 1'b0, 1'b0);
        do_read(24'hFFFFFF, 1'b0, 1'b0);

        // fast read with one dummy byte
        set_cfg(8'h0B, 2'd2, 2'd1, 2'd0, 8'h02, 6'd0);
        do_read(24'hABCDEF, 1'b0, 1'b0);
        // quad read, plus a stray request while busy (R9)
        set_cfg(8'h6B, 2'd2, 2'd1, 2'd3, 8'h02, 6'd0);
        do_read(24'h5A5A5A, 1'b0, 1'b1);
        do_read(24'hFFFFFC, 1'b0, 1'b0);
        // 1-byte and 4-byte address, max dummies, rtype 1 stays single-line
        set_cfg(8'hA7, 2'd0, 2'd0, 2'd1, 8'h00, 6'd0);
        do_read(24'h0000C3, 1'b0, 1'b1);
        set_cfg(8'hE1, 2'd3, 2'd3, 2'd3, 8'h00, 6'd0);
        do_read(24'h800001, 1'b0, 1'b0);
        // R10 write opcode and dummy-bit fields have no effect
        set_cfg(8'h6B, 2'd2, 2'd1, 2'd3, 8'hFF, 6'h3F);
        do_read(24'h5A5A5A, 1'b0, 1'b0);

        // random configurations and addresses
        for (int r = 0; r < 12; r++) begin
            set_cfg(8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                    8'($urandom), 6'($urandom));
            for (int k = 0; k < 4; k++) do_read(24'($urandom), 1'b0, (k == 2));
        end

        // R2 clearing the mode bit refuses again
        wr_reg(1'b1, 32'hFFFF_FFFE);
        do_read(24'h00ABCD, 1'b1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule